// File: doc/BRIEF.md
# MSI Termination Register Bank

This block terminates message-signalled interrupt writes. A bus master writes a small number (the message data) to the address of one of 128 index registers. The bank does not store that number. It treats the number as a bit position and sets that bit in the addressed register. The registers are arranged as 16 groups of 8 index registers, and each index register holds 16 vector bits, which gives 2048 vectors in total.

Software services a group in three steps. It reads the group's summary register to find out which index registers hold pending bits. It then reads each of those index registers, and each read clears the register it returns. Each group drives its own level interrupt output. That output stays high while any bit in the group is pending.

The read and write ports are plain single-cycle strobes. Read data is registered and appears in the cycle after the read strobe.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every vector bit is clear, every interrupt output is low, and every read returns zero.
- R2: A write whose data value d is below 16 sets bit d of the index register for group n and slot x. That register sits at offset (n << 19) + (x << 16), and the low 16 offset bits must be zero. The other bits of the register keep their values.
- R3: A read of an index register returns its 16 bits in rd_data[15:0], with the upper bits zero, in the cycle after rd_en. The same clock edge clears the register to zero. In a cycle after rd_en was low, rd_data is zero.
- R4: The summary register of group n sits at offset 0x800000 + (n << 16). A read of it returns, in bit x, a 1 exactly when index register x of that group holds a pending bit; the upper bits read as zero. Reading a summary register changes no state.
- R5: irq_out[n] is high exactly while some bit in group n is pending. It rises in the cycle after the setting write and falls in the cycle after the clearing read.
- R6: When a write and a clearing read hit the same index register in the same cycle, the read returns the old contents and the register afterwards holds only the newly written bit.
- R7: A write whose data value is 16 or more changes no state.
- R8: A write to an offset that decodes to no index register changes no state. A read of an offset that decodes to no register returns zero.
- R9: Successive writes to one index register accumulate their bits; setting a bit that is already set leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per message |
| wr_addr | input | 24 | Write offset from the bank base |
| wr_data | input | 32 | Message data, the bit number to set |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read offset from the bank base |
| rd_data | output | 32 | Registered read data, valid the cycle after rd_en |
| irq_out | output | 16 | One level interrupt per group |

## Verification
A lost or stuck vector bit shows at the ports in two places. It shows on irq_out in the cycle right after the edge that should have changed it, and it shows in the next summary or index read of that group. For this reason the bench compares irq_out on every cycle, not only when it issues reads. A wrong address decode sends a bit to the wrong group or slot, so the wrong interrupt line rises and a later read of the intended register returns zero. A clear ordered wrongly against a set loses a message silently, and only a same-cycle collision followed by a re-read exposes it.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  // Kind of register an offset selects
  typedef enum logic [1:0] {
    KIND_NONE    = 2'd0,
    KIND_INDEX   = 2'd1,
    KIND_SUMMARY = 2'd2
  } reg_kind_e;

  // Every register occupies one 64 KiB slot
  localparam int unsigned SLOT_SH = 16;
endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode
  import msi_term_pkg::*;
#(
  parameter int unsigned GRP_N = 16,
  parameter int unsigned REG_N = 8,
  localparam int unsigned GRP_W = $clog2(GRP_N),
  localparam int unsigned REG_W = $clog2(REG_N),
  localparam int unsigned ADDR_W = SLOT_SH + REG_W + GRP_W + 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [GRP_W-1:0]  grp,
  output logic [REG_W-1:0]  idx
);
  localparam int unsigned TOP = ADDR_W - 1;

  // Index region: top bit clear, group above slot field, slot-aligned
  // Summary region: top bit set, group in the slot field, gap bits zero
  function automatic reg_kind_e classify(input logic [ADDR_W-1:0] a);
    if (a[SLOT_SH-1:0] != '0) return KIND_NONE;
    if (!a[TOP]) return KIND_INDEX;
    if (a[TOP-1:SLOT_SH+GRP_W] == '0) return KIND_SUMMARY;
    return KIND_NONE;
  endfunction

  always_comb begin
    kind = classify(addr);
    idx  = addr[SLOT_SH +: REG_W];
    if (addr[TOP]) grp = addr[SLOT_SH +: GRP_W];
    else           grp = addr[SLOT_SH+REG_W +: GRP_W];
  end
endmodule

// File: rtl/msi_vec_reg.sv
module msi_vec_reg #(
  parameter int unsigned VEC_N = 16,
  localparam int unsigned BIT_W = $clog2(VEC_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [BIT_W-1:0] set_bit,
  input  logic             clr_en,
  output logic [VEC_N-1:0] bits
);
  logic [VEC_N-1:0] set_mask;
  logic [VEC_N-1:0] keep_mask;

  always_comb begin
    set_mask  = set_en ? (VEC_N'(1) << set_bit) : '0;
    keep_mask = clr_en ? '0 : bits;
  end

  // Clear first, then set: a colliding message is not lost
  always_ff @(posedge clk) begin
    if (!rst_n) bits <= '0;
    else        bits <= keep_mask | set_mask;
  end

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> bits[$past(set_bit)]);
  p_clear_empties_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> (bits == '0));
  p_collision_keeps_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en) |=> ($countones(bits) == 1));
  p_bits_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((bits & $past(bits)) == $past(bits)));
endmodule

// File: rtl/msi_group_summary.sv
module msi_group_summary #(
  parameter int unsigned REG_N = 8,
  parameter int unsigned VEC_N = 16
) (
  input  logic [REG_N*VEC_N-1:0] grp_bits,
  output logic [REG_N-1:0]       summary,
  output logic                   irq
);
  for (genvar r = 0; r < REG_N; r++) begin : g_slot
    assign summary[r] = |grp_bits[r*VEC_N +: VEC_N];
  end
  assign irq = |summary;
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_term_pkg::*;
#(
  parameter int unsigned GRP_N = 16,
  parameter int unsigned REG_N = 8,
  parameter int unsigned VEC_N = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned GRP_W = $clog2(GRP_N),
  localparam int unsigned REG_W = $clog2(REG_N),
  localparam int unsigned BIT_W = $clog2(VEC_N),
  localparam int unsigned ADDR_W = SLOT_SH + REG_W + GRP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [GRP_N-1:0]  irq_out
);
  reg_kind_e        wr_kind, rd_kind;
  logic [GRP_W-1:0] wr_grp, rd_grp;
  logic [REG_W-1:0] wr_idx, rd_idx;

  msi_addr_decode #(.GRP_N(GRP_N), .REG_N(REG_N)) u_wr_dec (
    .addr(wr_addr), .kind(wr_kind), .grp(wr_grp), .idx(wr_idx));
  msi_addr_decode #(.GRP_N(GRP_N), .REG_N(REG_N)) u_rd_dec (
    .addr(rd_addr), .kind(rd_kind), .grp(rd_grp), .idx(rd_idx));

  // Named events for the assertions
  logic wr_accept;
  logic rd_clear;
  assign wr_accept = wr_en && (wr_kind == KIND_INDEX) && (wr_data < DATA_W'(VEC_N));
  assign rd_clear  = rd_en && (rd_kind == KIND_INDEX);

  logic [VEC_N-1:0]       vec_q   [GRP_N][REG_N];
  logic [REG_N*VEC_N-1:0] grp_bus [GRP_N];
  logic [REG_N-1:0]       summary [GRP_N];

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    for (genvar r = 0; r < REG_N; r++) begin : g_reg
      logic set_here, clr_here;
      assign set_here = wr_accept && (wr_grp == GRP_W'(g)) && (wr_idx == REG_W'(r));
      assign clr_here = rd_clear  && (rd_grp == GRP_W'(g)) && (rd_idx == REG_W'(r));
      msi_vec_reg #(.VEC_N(VEC_N)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_here), .set_bit(wr_data[BIT_W-1:0]),
        .clr_en(clr_here), .bits(vec_q[g][r]));
      assign grp_bus[g][r*VEC_N +: VEC_N] = vec_q[g][r];
    end
    msi_group_summary #(.REG_N(REG_N), .VEC_N(VEC_N)) u_sum (
      .grp_bits(grp_bus[g]), .summary(summary[g]), .irq(irq_out[g]));
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      case (rd_kind)
        KIND_INDEX:   rd_next = DATA_W'(vec_q[rd_grp][rd_idx]);
        KIND_SUMMARY: rd_next = DATA_W'(summary[rd_grp]);
        default:      rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

  p_accept_raises_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> irq_out[$past(wr_grp)]);
  p_undecoded_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_kind == KIND_NONE) |=> (rd_data == '0));
  p_big_data_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data >= DATA_W'(VEC_N) && !rd_en) |=> $stable(irq_out));
  p_idle_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
endmodule

// File: tb/test_msi_term_bank.sv
module test_msi_term_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m [16][8];

  always #2 clk = ~clk;

  msi_term_bank i_msi_term_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out));

  function automatic bit is_idx(input logic [23:0] a);
    return (a < 24'h800000) && (a % 65536 == 0);
  endfunction
  function automatic bit is_sum(input logic [23:0] a);
    return (a >= 24'h800000) && (a < 24'h900000) && (a % 65536 == 0);
  endfunction
  function automatic int grp_of(input logic [23:0] a);
    return is_idx(a) ? int'(a / 524288) : int'((a - 24'h800000) / 65536);
  endfunction
  function automatic int slot_of(input logic [23:0] a);
    return int'((a / 65536) % 8);
  endfunction
  function automatic logic [31:0] exp_read(input logic [23:0] a);
    logic [31:0] v = '0;
    if (is_idx(a)) v = {16'h0, m[grp_of(a)][slot_of(a)]};
    else if (is_sum(a))
      for (int x = 0; x < 8; x++) v[x] = (m[grp_of(a)][x] != 0);
    return v;
  endfunction
  function automatic logic [15:0] exp_irq();
    logic [15:0] v = '0;
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) if (m[g][x] != 0) v[g] = 1'b1;
    return v;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check at the following negedge
  task automatic cyc(input bit we, input logic [23:0] wa, input logic [31:0] wd,
                     input bit re, input logic [23:0] ra, input string req);
    logic [31:0] er;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    er = re ? exp_read(ra) : 32'h0;
    if (re && is_idx(ra)) m[grp_of(ra)][slot_of(ra)] = 16'h0;
    if (we && is_idx(wa) && wd < 16) m[grp_of(wa)][slot_of(wa)][wd[3:0]] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0;
    check(req, "rd_data", rd_data, er);
    check(req, "irq_out", {16'h0, irq_out}, {16'h0, exp_irq()});
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input string req);
    cyc(1, a, d, 0, 24'h0, req);
  endtask
  task automatic rd(input logic [23:0] a, input string req);
    cyc(0, 24'h0, 32'h0, 1, a, req);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1badcafe));
    for (int g = 0; g < 16; g++) for (int x = 0; x < 8; x++) m[g][x] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1", "irq_out", {16'h0, irq_out}, 32'h0);
    rd(24'h800000, "R1"); rd(24'h8F0000, "R1"); rd(24'h000000, "R1");
    // R2, R4, R5: single message, group 0 slot 1
    wr(24'h010000, 32'd5, "R2");
    rd(24'h800000, "R4");
    rd(24'h800000, "R4");
    rd(24'h010000, "R3");
    rd(24'h010000, "R3");
    // R9: accumulation in group 1 slot 0, with a repeat
    wr(24'h080000, 32'd15, "R9"); wr(24'h080000, 32'd0, "R9"); wr(24'h080000, 32'd0, "R9");
    rd(24'h080000, "R9");
    // Highest group and slot
    wr(24'h7F0000, 32'd3, "R2"); rd(24'h8F0000, "R4"); rd(24'h7F0000, "R5");
    // R7: out-of-range data
    wr(24'h000000, 32'd16, "R7"); wr(24'h000000, 32'hFFFFFFFF, "R7");
    rd(24'h000000, "R7");
    // R8: undecoded writes and reads
    wr(24'h010004, 32'd2, "R8"); wr(24'h810000 | 24'h100000, 32'd2, "R8");
    rd(24'h900000, "R8"); rd(24'h008000, "R8"); rd(24'h800000, "R8");
    // R6: collision of write and clearing read
    wr(24'h230000, 32'd7, "R6");
    cyc(1, 24'h230000, 32'd9, 1, 24'h230000, "R6");
    rd(24'h230000, "R6");
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [23:0] wa, ra;
      int k;
      k = $urandom % 100;
      if (k < 65) wa = 24'(($urandom % 16) << 19 | ($urandom % 8) << 16);
      else wa = 24'($urandom);
      k = $urandom % 100;
      if (k < 50) ra = 24'(($urandom % 16) << 19 | ($urandom % 8) << 16);
      else if (k < 80) ra = 24'(24'h800000 | ($urandom % 16) << 16);
      else ra = 24'($urandom);
      cyc(($urandom % 4) != 0, wa, 32'($urandom % 20), ($urandom % 3) == 0, ra, "R2/R3/R4/R5 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule